// File: doc/BRIEF.md
# Branch Target and Interworking Unit

This unit resolves where execution continues after a branch in an instruction set whose instructions are 2 or 4 bytes long and aligned to halfwords. A decoder hands it one branch at a time with a one-cycle `start` pulse. The pulse carries the branch kind, the instruction address, the instruction length, the immediate offset, two register operands and the `taken` flag from an external condition evaluator. The unit returns the next program counter. For call forms it also returns a link value. It keeps the current instruction-set mode, compact or word-aligned, in its own register.

All offsets are measured from the instruction address plus 4. Register branches use bit 0 of the operand as the mode select and clear it from the address. Table branches need a memory read, issued through a simple request/acknowledge port. The unit reads an unsigned byte or halfword there and adds twice its value to the same base. All address arithmetic wraps modulo 2^32.

The controller has three states. ST_IDLE waits for `start`. ST_READ holds the table read until `mem_ack`. ST_DONE presents the result for exactly one cycle and then returns to ST_IDLE. The transitions are:
- ST_IDLE to ST_READ on a taken table branch.
- ST_IDLE to ST_DONE on any other accepted operation.
- ST_READ to ST_DONE on `mem_ack`.
- ST_DONE to ST_IDLE always.

Top module: `btu_branch_unit`

## Requirements
- R1: After reset the unit is in ST_IDLE with `busy`, `done`, `mem_req`, `link_we` and `align_fault` low. `mode_compact` is 1 and `link_reg` is 0.
- R2: Kind 0 (relative), when taken, yields `next_pc` = `insn_addr` + 4 + `imm`. Bit 0 of `imm` is treated as 0. The sum wraps modulo 2^32.
- R3: Kind 1 (forward zero-test branch), when taken, yields `insn_addr` + 4 + the unsigned value of `imm[6:1]`×2. Bits of `imm` above bit 6 are ignored.
- R4: Kind 2 (call), when taken, yields the relative target of R2. It also pulses `link_we` and loads `link_reg` with (`insn_addr` + length) with bit 0 set, where length is 4 when `insn_wide`=1 and 2 otherwise.
- R5: Kind 3 (register exchange) and kind 4 (register exchange call), when taken, yield `rn_val` with bit 0 cleared. They set `mode_compact` to `rn_val[0]`. Kind 4 also writes the link as in R4.
- R6: A taken kind 3 or 4 whose `rn_val[1:0]` is 2'b10 raises `align_fault` with `done`. It yields the sequential address and leaves `mode_compact` and `link_reg` unchanged.
- R7: When `taken` is 0, and for kind 7 (none), `next_pc` is `insn_addr` + length. No link is written, `mode_compact` is unchanged and no memory read occurs.
- R8: Kind 5 (byte table), when taken, requests `mem_addr` = `rn_val` + `rm_val` with `mem_half`=0. It yields `insn_addr` + 4 + 2×`mem_rdata[7:0]`.
- R9: Kind 6 (halfword table), when taken, requests `mem_addr` = `rn_val` + 2×`rm_val` with `mem_half`=1. It yields `insn_addr` + 4 + 2×`mem_rdata[15:0]`.
- R10: A non-table operation shows `done` in the cycle after the `start` edge. A table operation shows `done` in the cycle after the `mem_ack` edge. `done` lasts one cycle. `busy` is high in ST_READ and ST_DONE, and `start` is ignored while `busy` is high.
- R11: `mem_req` stays high with stable `mem_addr` and `mem_half` until the cycle in which `mem_ack` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a branch operation (ignored while busy) |
| br_kind | input | 3 | Branch kind code, 0 to 7 as listed in the requirements |
| insn_addr | input | AW | Address of the branch instruction |
| insn_wide | input | 1 | 1 for a 4-byte instruction, 0 for 2 bytes |
| imm | input | AW | Byte offset for relative forms |
| rn_val | input | AW | Register target or table base |
| rm_val | input | AW | Table index |
| taken | input | 1 | Condition result from the evaluator |
| mem_ack | input | 1 | Table read data valid |
| mem_rdata | input | DW | Table read data, byte in bits 7:0 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid this cycle |
| next_pc | output | AW | Resolved next program counter |
| link_we | output | 1 | Link value written this operation |
| link_reg | output | AW | Current link value |
| mode_compact | output | 1 | 1 when in the compact instruction set |
| align_fault | output | 1 | Register target not word-aligned |
| mem_req | output | 1 | Table read request |
| mem_addr | output | AW | Table entry address |
| mem_half | output | 1 | 1 for a halfword read, 0 for a byte read |

## Verification
There is one register between the inputs and the results. A non-table operation therefore has `done`, `next_pc`, `link_we`, `align_fault` and the updated `mode_compact`/`link_reg` one cycle after the edge that samples `start`. A table operation raises `mem_req` one cycle after `start` and has its results one cycle after the edge that samples `mem_ack`. The bench drives on falling edges and samples at the first falling edge after the edge that loads the result. One cycle later it checks that `done` and `busy` have dropped, so a stretched or early pulse shows up as a mismatch.

// File: rtl/btu_pkg.sv
package btu_pkg;

    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        BK_REL   = 3'd0,
        BK_ZFWD  = 3'd1,
        BK_CALL  = 3'd2,
        BK_XREG  = 3'd3,
        BK_XCALL = 3'd4,
        BK_TBYTE = 3'd5,
        BK_THALF = 3'd6,
        BK_NONE  = 3'd7
    } br_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_DONE = 2'd2
    } btu_state_e;

    function automatic logic is_table(input br_kind_e k);
        return (k == BK_TBYTE) || (k == BK_THALF);
    endfunction

endpackage

// File: rtl/btu_table_addr.sv
module btu_table_addr
    import btu_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 16
) (
    input  br_kind_e         kind,
    input  logic [AW-1:0]    base,
    input  logic [AW-1:0]    index,
    input  logic [DW-1:0]    rdata,
    output logic [AW-1:0]    entry_addr,
    output logic             entry_half,
    output logic [DW-1:0]    entry_off
);
    localparam int BYTE_W = 8;

    always_comb begin
        entry_half = (kind == BK_THALF);
        if (entry_half) begin
            entry_addr = base + (index << 1);
            entry_off  = rdata;
        end else begin
            entry_addr = base + index;
            entry_off  = {{(DW-BYTE_W){1'b0}}, rdata[BYTE_W-1:0]};
        end
    end
endmodule

// File: rtl/btu_target_calc.sv
module btu_target_calc
    import btu_pkg::*;
#(
    parameter int AW = 32,
    parameter int ZW = 7,
    parameter int DW = 16
) (
    input  br_kind_e         kind,
    input  logic [AW-1:0]    addr,
    input  logic             wide,
    input  logic [AW-1:0]    imm,
    input  logic [AW-1:0]    rn,
    input  logic             taken,
    input  logic [DW-1:0]    tbl_off,
    input  logic             cur_mode,
    output logic [AW-1:0]    target,
    output logic [AW-1:0]    link_val,
    output logic             link_wr,
    output logic             new_mode,
    output logic             fault
);
    localparam logic [AW-1:0] PC_BIAS = AW'(4);

    logic [AW-1:0] pc_base, seq_pc, rel_tgt, zfwd_tgt, tbl_tgt, reg_tgt;
    logic          reg_bad;

    always_comb begin
        pc_base  = addr + PC_BIAS;
        seq_pc   = addr + (wide ? AW'(4) : AW'(2));
        rel_tgt  = pc_base + {imm[AW-1:1], 1'b0};
        zfwd_tgt = pc_base + {{(AW-ZW){1'b0}}, imm[ZW-1:1], 1'b0};
        tbl_tgt  = pc_base + {{(AW-DW-1){1'b0}}, tbl_off, 1'b0};
        reg_tgt  = {rn[AW-1:1], 1'b0};
        reg_bad  = (rn[1:0] == 2'b10);
        link_val = seq_pc | AW'(1);
    end

    always_comb begin
        target   = seq_pc;
        link_wr  = 1'b0;
        new_mode = cur_mode;
        fault    = 1'b0;
        if (taken) begin
            unique case (kind)
                BK_REL:   target = rel_tgt;
                BK_ZFWD:  target = zfwd_tgt;
                BK_CALL: begin
                    target  = rel_tgt;
                    link_wr = 1'b1;
                end
                BK_XREG, BK_XCALL: begin
                    if (reg_bad) begin
                        fault = 1'b1;
                    end else begin
                        target   = reg_tgt;
                        new_mode = rn[0];
                        link_wr  = (kind == BK_XCALL);
                    end
                end
                BK_TBYTE, BK_THALF: target = tbl_tgt;
                BK_NONE:  target = seq_pc;
            endcase
        end
    end
endmodule

// File: rtl/btu_branch_unit.sv
module btu_branch_unit
    import btu_pkg::*;
#(
    parameter int AW = 32,
    parameter int ZW = 7,
    parameter int DW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [KIND_W-1:0]   br_kind,
    input  logic [AW-1:0]       insn_addr,
    input  logic                insn_wide,
    input  logic [AW-1:0]       imm,
    input  logic [AW-1:0]       rn_val,
    input  logic [AW-1:0]       rm_val,
    input  logic                taken,
    input  logic                mem_ack,
    input  logic [DW-1:0]       mem_rdata,
    output logic                busy,
    output logic                done,
    output logic [AW-1:0]       next_pc,
    output logic                link_we,
    output logic [AW-1:0]       link_reg,
    output logic                mode_compact,
    output logic                align_fault,
    output logic                mem_req,
    output logic [AW-1:0]       mem_addr,
    output logic                mem_half
);
    btu_state_e    st_q, st_d;

    br_kind_e      kind_q;
    logic [AW-1:0] addr_q, imm_q, rn_q, rm_q;
    logic          wide_q, taken_q;

    br_kind_e      kind_in;
    logic          accept, tbl_go, load_res;

    br_kind_e      c_kind;
    logic [AW-1:0] c_addr, c_imm, c_rn;
    logic          c_wide, c_taken;

    logic [DW-1:0] tbl_off;
    logic [AW-1:0] c_target, c_link;
    logic          c_link_wr, c_mode, c_fault;

    logic [AW-1:0] pc_q, link_q;
    logic          lwe_q, fault_q, mode_q;

    assign kind_in  = br_kind_e'(br_kind);
    assign accept   = (st_q == ST_IDLE) && start;
    assign tbl_go   = taken && is_table(kind_in);
    assign load_res = (accept && !tbl_go) || ((st_q == ST_READ) && mem_ack);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = tbl_go ? ST_READ : ST_DONE;
            ST_READ: if (mem_ack) st_d = ST_DONE;
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // operand capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= BK_NONE;
            addr_q  <= '0;
            imm_q   <= '0;
            rn_q    <= '0;
            rm_q    <= '0;
            wide_q  <= 1'b0;
            taken_q <= 1'b0;
        end else if (accept) begin
            kind_q  <= kind_in;
            addr_q  <= insn_addr;
            imm_q   <= imm;
            rn_q    <= rn_val;
            rm_q    <= rm_val;
            wide_q  <= insn_wide;
            taken_q <= taken;
        end
    end

    // live operands in idle, captured ones while reading
    always_comb begin
        if (st_q == ST_IDLE) begin
            c_kind  = kind_in;
            c_addr  = insn_addr;
            c_imm   = imm;
            c_rn    = rn_val;
            c_wide  = insn_wide;
            c_taken = taken;
        end else begin
            c_kind  = kind_q;
            c_addr  = addr_q;
            c_imm   = imm_q;
            c_rn    = rn_q;
            c_wide  = wide_q;
            c_taken = taken_q;
        end
    end

    btu_table_addr #(.AW(AW), .DW(DW)) u_tbl (
        .kind       (kind_q),
        .base       (rn_q),
        .index      (rm_q),
        .rdata      (mem_rdata),
        .entry_addr (mem_addr),
        .entry_half (mem_half),
        .entry_off  (tbl_off)
    );

    btu_target_calc #(.AW(AW), .ZW(ZW), .DW(DW)) u_calc (
        .kind     (c_kind),
        .addr     (c_addr),
        .wide     (c_wide),
        .imm      (c_imm),
        .rn       (c_rn),
        .taken    (c_taken),
        .tbl_off  (tbl_off),
        .cur_mode (mode_q),
        .target   (c_target),
        .link_val (c_link),
        .link_wr  (c_link_wr),
        .new_mode (c_mode),
        .fault    (c_fault)
    );

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            link_q  <= '0;
            lwe_q   <= 1'b0;
            fault_q <= 1'b0;
            mode_q  <= 1'b1;
        end else begin
            lwe_q   <= load_res && c_link_wr;
            fault_q <= load_res && c_fault;
            if (load_res) begin
                pc_q   <= c_target;
                mode_q <= c_mode;
            end
            if (load_res && c_link_wr) link_q <= c_link;
        end
    end

    // outputs
    always_comb begin
        busy         = (st_q != ST_IDLE);
        done         = (st_q == ST_DONE);
        mem_req      = (st_q == ST_READ);
        next_pc      = pc_q;
        link_we      = lwe_q;
        link_reg     = link_q;
        mode_compact = mode_q;
        align_fault  = fault_q;
    end
endmodule

// File: rtl/btu_branch_unit_chk.sv
module btu_branch_unit_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic [AW-1:0] next_pc,
    input logic          link_we,
    input logic [AW-1:0] link_reg,
    input logic          mode_compact,
    input logic          align_fault,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic          mem_half
);
    // R10
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (busy && !done));

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_half)));

    // R4
    link_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_reg[0] && done));

    // R2
    pc_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !next_pc[0]);

    // R6
    fault_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && align_fault) |-> (mode_compact == $past(mode_compact) && !link_we));

    // R7
    mode_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_compact != $past(mode_compact)) |-> done);
endmodule

bind btu_branch_unit btu_branch_unit_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (done),
    .next_pc      (next_pc),
    .link_we      (link_we),
    .link_reg     (link_reg),
    .mode_compact (mode_compact),
    .align_fault  (align_fault),
    .mem_req      (mem_req),
    .mem_ack      (mem_ack),
    .mem_addr     (mem_addr),
    .mem_half     (mem_half)
);

// File: tb/tb_btu_branch_unit.sv
module tb_btu_branch_unit;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 16;
    localparam int NV = 17;
    localparam int WD_CYCLES = 20000;

    typedef struct packed {
        logic [2:0]    kind;
        logic [AW-1:0] addr;
        logic          wide;
        logic [AW-1:0] imm;
        logic [AW-1:0] rn;
        logic          taken;
        logic [AW-1:0] pc;
        logic          lwe;
        logic [AW-1:0] link;
        logic          mode;
        logic          fault;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{3'd0, 32'h1000, 1'b0, 32'h10, 32'h0, 1'b1, 32'h1014, 1'b0, 32'h0, 1'b1, 1'b0},         // R2
        '{3'd0, 32'h2000, 1'b0, 32'hFFFFFF00, 32'h0, 1'b1, 32'h1F04, 1'b0, 32'h0, 1'b1, 1'b0},   // R2 backward
        '{3'd0, 32'h3000, 1'b1, 32'h40, 32'h0, 1'b0, 32'h3004, 1'b0, 32'h0, 1'b1, 1'b0},         // R7
        '{3'd0, 32'h3100, 1'b0, 32'h40, 32'h0, 1'b0, 32'h3102, 1'b0, 32'h0, 1'b1, 1'b0},         // R7
        '{3'd1, 32'h4000, 1'b0, 32'hFFFFFF7E, 32'h0, 1'b1, 32'h4082, 1'b0, 32'h0, 1'b1, 1'b0},   // R3
        '{3'd2, 32'h5000, 1'b1, 32'h100, 32'h0, 1'b1, 32'h5104, 1'b1, 32'h5005, 1'b1, 1'b0},     // R4
        '{3'd2, 32'h5100, 1'b1, 32'h100, 32'h0, 1'b0, 32'h5104, 1'b0, 32'h0, 1'b1, 1'b0},        // R7
        '{3'd3, 32'h6000, 1'b0, 32'h0, 32'h8001, 1'b1, 32'h8000, 1'b0, 32'h0, 1'b1, 1'b0},       // R5
        '{3'd3, 32'h6000, 1'b0, 32'h0, 32'h9000, 1'b1, 32'h9000, 1'b0, 32'h0, 1'b0, 1'b0},       // R5
        '{3'd3, 32'h6000, 1'b0, 32'h0, 32'hA002, 1'b1, 32'h6002, 1'b0, 32'h0, 1'b0, 1'b1},       // R6
        '{3'd4, 32'h7000, 1'b0, 32'h0, 32'hB001, 1'b1, 32'hB000, 1'b1, 32'h7003, 1'b1, 1'b0},    // R5
        '{3'd0, 32'hFFFFFFF0, 1'b0, 32'h20, 32'h0, 1'b1, 32'h14, 1'b0, 32'h0, 1'b1, 1'b0},       // R2 wrap
        '{3'd3, 32'h7100, 1'b0, 32'h0, 32'h1000, 1'b0, 32'h7102, 1'b0, 32'h0, 1'b1, 1'b0},       // R7
        '{3'd7, 32'h7200, 1'b1, 32'h0, 32'h0, 1'b1, 32'h7204, 1'b0, 32'h0, 1'b1, 1'b0},          // R7
        '{3'd0, 32'h1000, 1'b0, 32'h11, 32'h0, 1'b1, 32'h1014, 1'b0, 32'h0, 1'b1, 1'b0},         // R2 odd imm
        '{3'd4, 32'h7300, 1'b1, 32'h0, 32'hC00E, 1'b1, 32'h7304, 1'b0, 32'h0, 1'b1, 1'b1},       // R6
        '{3'd5, 32'h7400, 1'b1, 32'h0, 32'h2000, 1'b0, 32'h7404, 1'b0, 32'h0, 1'b1, 1'b0}        // R7
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    br_kind = 3'd0;
    logic [AW-1:0] insn_addr = '0;
    logic          insn_wide = 1'b0;
    logic [AW-1:0] imm = '0;
    logic [AW-1:0] rn_val = '0;
    logic [AW-1:0] rm_val = '0;
    logic          taken = 1'b0;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          busy, done, link_we, mode_compact, align_fault, mem_req, mem_half;
    logic [AW-1:0] next_pc, link_reg, mem_addr;

    int n_checks = 0;
    int n_fails = 0;
    logic [AW-1:0] exp_link = '0;
    bit finished = 1'b0;

    btu_branch_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .br_kind(br_kind),
        .insn_addr(insn_addr), .insn_wide(insn_wide), .imm(imm),
        .rn_val(rn_val), .rm_val(rm_val), .taken(taken),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .next_pc(next_pc), .link_we(link_we),
        .link_reg(link_reg), .mode_compact(mode_compact),
        .align_fault(align_fault), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_half(mem_half)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] k, input logic [AW-1:0] a, input logic w,
                         input logic [AW-1:0] im, input logic [AW-1:0] rn,
                         input logic [AW-1:0] rm, input logic t);
        @(negedge clk);
        br_kind = k; insn_addr = a; insn_wide = w; imm = im;
        rn_val = rn; rm_val = rm; taken = t; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic table_op(input logic [2:0] k, input logic [AW-1:0] rn, input logic [AW-1:0] rm,
                            input logic [AW-1:0] exp_addr, input logic exp_half,
                            input logic [DW-1:0] data, input logic [AW-1:0] exp_pc, input string req);
        issue(k, 32'h100, 1'b1, 32'h0, rn, rm, 1'b1);
        check({req, " req"}, {31'd0, mem_req}, 32'd1);
        check({req, " addr"}, mem_addr, exp_addr);
        check({req, " size"}, {31'd0, mem_half}, {31'd0, exp_half});
        check("R10 busy in read", {31'd0, busy}, 32'd1);
        // R10: a start during the read must be ignored
        start = 1'b1; br_kind = 3'd0; insn_addr = 32'h9999_0000; taken = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R11 req held", {31'd0, mem_req}, 32'd1);
        check("R11 addr held", mem_addr, exp_addr);
        @(negedge clk);
        mem_ack = 1'b1; mem_rdata = data;
        @(negedge clk);
        mem_ack = 1'b0; mem_rdata = '0;
        check({req, " done"}, {31'd0, done}, 32'd1);
        check({req, " pc"}, next_pc, exp_pc);
        check({req, " no link"}, {31'd0, link_we}, 32'd0);
        check({req, " mode"}, {31'd0, mode_compact}, 32'd1);
        @(negedge clk);
        check("R10 idle after table", {30'd0, busy, done}, 32'd0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 req", {31'd0, mem_req}, 32'd0);
        check("R1 mode", {31'd0, mode_compact}, 32'd1);
        check("R1 link", link_reg, 32'd0);
        check("R1 pulses", {30'd0, link_we, align_fault}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].kind, VECS[i].addr, VECS[i].wide, VECS[i].imm,
                  VECS[i].rn, 32'h0, VECS[i].taken);
            if (VECS[i].lwe) exp_link = VECS[i].link;
            check("R10 done timing", {31'd0, done}, 32'd1);
            check("R7 no read", {31'd0, mem_req}, 32'd0);
            check("R2/R3/R5 pc", next_pc, VECS[i].pc);
            check("R4 link we", {31'd0, link_we}, {31'd0, VECS[i].lwe});
            check("R4/R6 link", link_reg, exp_link);
            check("R5/R6 mode", {31'd0, mode_compact}, {31'd0, VECS[i].mode});
            check("R6 fault", {31'd0, align_fault}, {31'd0, VECS[i].fault});
            @(negedge clk);
            check("R10 single done", {30'd0, busy, done}, 32'd0);
        end

        // R8 byte table: 0x104 + 2*0x37
        table_op(3'd5, 32'h2000, 32'd5, 32'h2005, 1'b0, 16'hAB37, 32'h172, "R8");
        // R9 halfword table: 0x104 + 2*0x8001
        table_op(3'd6, 32'h3000, 32'd4, 32'h3008, 1'b1, 16'h8001, 32'h10106, "R9");

        // R1 reset mid-operation
        issue(3'd3, 32'h0, 1'b0, 32'h0, 32'h4000, 32'h0, 1'b1);
        check("R5 mode before reset", {31'd0, mode_compact}, 32'd0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 mode after reset", {31'd0, mode_compact}, 32'd1);
        check("R1 link after reset", link_reg, 32'd0);
        check("R1 idle after reset", {30'd0, busy, done}, 32'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule